// File: doc/BRIEF.md
# Debug Serial Port Register Front End

This block is the software-facing side of a simple debug serial port. It decodes a 512-byte window of 32-bit registers: a control word, a mode word, a baud divisor, a write-one-to-set interrupt enable port, a write-one-to-clear interrupt disable port, a readable interrupt mask, a status word, a receive holding port and a transmit holding port. A peripheral-DMA transfer-status location is decoded and always reads as zero. The bit-level serial engine sits outside. It pushes received bytes into the block and takes transmit bytes from it.

Received bytes wait in a small FIFO and software drains them by reading the receive holding port. A single level-sensitive interrupt line is raised when a byte is accepted while receive interrupts are enabled, or when a transmit byte is written while transmit interrupts are enabled. The line is cleared by a status read that finds the receive FIFO empty. Bus accesses take one cycle, and read data is registered.

Top module: `dbg_uart_regs`

## Requirements
- R1: After reset the interrupt output is low, the mask, control, mode and divisor read 0, the receive FIFO is empty, and the status word reads 0x00000A02.
- R2: Registers sit at byte offsets control 0x000, mode 0x004, enable 0x008, disable 0x00C, mask 0x010, status 0x014, receive 0x018, transmit 0x01C, divisor 0x020 and transfer-status 0x124. Reads of enable, disable, transmit, transfer-status, unmapped or unaligned offsets return 0. Writes to mask, status, receive, transfer-status or unmapped offsets change nothing.
- R3: A control write keeps only bits [7:2], a mode write keeps bits [11:0] and a divisor write keeps bits [15:0]. Each reads back at its own offset.
- R4: Writing the enable port ORs the data into the 32-bit mask. Writing the disable port clears each mask bit written as 1. The mask offset reads back the current mask.
- R5: The status word has bit 0 set when the receive FIFO is not empty, bit 5 set when the overrun flag is set, and bits 1, 9 and 11 always set. All other bits are 0.
- R6: The receive FIFO holds DEPTH (default 16) bytes in arrival order. A read of the receive port returns the oldest byte in bits [7:0] and removes it. When the FIFO is empty the read returns 0.
- R7: A byte offered while the FIFO is full at the start of that cycle is dropped, even if a pop happens in the same cycle. A dropped byte sets the overrun flag, which stays set until reset.
- R8: An accepted byte with mask bit 0 set sets receive-pending, and the interrupt output is high from the next cycle.
- R9: A transmit-port write pulses tx_valid for exactly one cycle, the cycle after the write, with tx_byte equal to bits [7:0] of the data. If mask bit 4 is set, it also sets transmit-pending and raises the interrupt.
- R10: A status read that finds the FIFO empty clears all pending state, and the interrupt output is low the next cycle. A byte accepted in that same cycle still sets receive-pending. A status read with a non-empty FIFO leaves pending state unchanged.
- R11: Read data appears on bus_rdata the cycle after the read request and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW (9) | Byte offset within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| rx_valid | input | 1 | Serial engine offers a received byte |
| rx_byte | input | 8 | Received byte |
| tx_valid | output | 1 | One-cycle pulse: transmit byte ready |
| tx_byte | output | 8 | Byte to transmit |
| irq | output | 1 | Level interrupt |

## Verification
A wrong FIFO pointer or count shows at the ports as a wrong byte, or a spurious zero, on the very next receive-port read. A drifting count also shows as a wrong bit 0 or bit 5 in the next status word. A wrong pending or mask state shows on irq one cycle after the event that should have changed it. The bench compares irq, read data and the transmit pulse against a behavioural model on every clock, so a divergence is reported in the first cycle it becomes visible.

// File: rtl/dbgu_pkg.sv
package dbgu_pkg;
  localparam logic [11:0] OFF_CTRL = 12'h000;
  localparam logic [11:0] OFF_MODE = 12'h004;
  localparam logic [11:0] OFF_IEN  = 12'h008;
  localparam logic [11:0] OFF_IDIS = 12'h00C;
  localparam logic [11:0] OFF_MASK = 12'h010;
  localparam logic [11:0] OFF_STAT = 12'h014;
  localparam logic [11:0] OFF_RHR  = 12'h018;
  localparam logic [11:0] OFF_THR  = 12'h01C;
  localparam logic [11:0] OFF_DIV  = 12'h020;
  localparam logic [11:0] OFF_XFER = 12'h124;

  localparam int ST_RXRDY = 0;
  localparam int ST_TXRDY = 1;
  localparam int ST_OVR   = 5;
  localparam int ST_TXEMP = 9;
  localparam int ST_TXBUF = 11;

  localparam int MB_RX = 0;
  localparam int MB_TX = 4;

  function automatic logic [31:0] trim_ctrl(input logic [31:0] d);
    return d & 32'h0000_00FC;
  endfunction

  function automatic logic [31:0] trim_mode(input logic [31:0] d);
    return d & 32'h0000_0FFF;
  endfunction

  function automatic logic [31:0] trim_div(input logic [31:0] d);
    return d & 32'h0000_FFFF;
  endfunction

  function automatic logic [31:0] status_word(input logic nonempty, input logic ovr);
    logic [31:0] s;
    s = '0;
    s[ST_RXRDY] = nonempty;
    s[ST_TXRDY] = 1'b1;
    s[ST_OVR]   = ovr;
    s[ST_TXEMP] = 1'b1;
    s[ST_TXBUF] = 1'b1;
    return s;
  endfunction
endpackage

// File: rtl/dbgu_rxq.sv
module dbgu_rxq #(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_req,
  input  logic [W-1:0]  din,
  input  logic          pop_req,
  output logic          push_ok,
  output logic          drop,
  output logic [CW-1:0] count,
  output logic [W-1:0]  head
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] rd_ptr, wr_ptr;
  logic          pop_ok;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign push_ok = push_req && (count != CW'(DEPTH));
  assign drop    = push_req && (count == CW'(DEPTH));
  assign pop_ok  = pop_req && (count != '0);
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= bump(wr_ptr);
      if (pop_ok)  rd_ptr <= bump(rd_ptr);
      count <= count + CW'(push_ok) - CW'(pop_ok);
    end
  end
endmodule

// File: rtl/dbgu_irq.sv
module dbgu_irq (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        set_en,
  input  logic        clr_en,
  input  logic [31:0] wdata,
  input  logic        evt_rx,
  input  logic        evt_tx,
  input  logic        clr_all,
  output logic [31:0] mask,
  output logic        irq
);
  import dbgu_pkg::*;
  logic [1:0] pend, pend_nxt;

  always_comb begin
    pend_nxt = clr_all ? 2'b00 : pend;
    if (evt_rx && mask[MB_RX]) pend_nxt[0] = 1'b1;
    if (evt_tx && mask[MB_TX]) pend_nxt[1] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask <= '0;
      pend <= '0;
    end else begin
      if (set_en)      mask <= mask | wdata;
      else if (clr_en) mask <= mask & ~wdata;
      pend <= pend_nxt;
    end
  end

  assign irq = |pend;
endmodule

// File: rtl/dbgu_cfg.sv
module dbgu_cfg (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we_ctrl,
  input  logic        we_mode,
  input  logic        we_div,
  input  logic [31:0] wdata,
  output logic [31:0] ctrl,
  output logic [31:0] mode,
  output logic [31:0] div
);
  import dbgu_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl <= '0;
      mode <= '0;
      div  <= '0;
    end else begin
      if (we_ctrl) ctrl <= trim_ctrl(wdata);
      if (we_mode) mode <= trim_mode(wdata);
      if (we_div)  div  <= trim_div(wdata);
    end
  end
endmodule

// File: rtl/dbg_uart_regs.sv
module dbg_uart_regs #(
  parameter int DEPTH = 16,
  parameter int AW    = 9,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  input  logic          rx_valid,
  input  logic [7:0]    rx_byte,
  output logic          tx_valid,
  output logic [7:0]    tx_byte,
  output logic          irq
);
  import dbgu_pkg::*;

  logic          wr_en, rd_en;
  logic          q_push, q_drop, q_pop;
  logic [CW-1:0] q_count;
  logic [7:0]    q_head;
  logic          ovr_flag;
  logic          evt_clr_all, evt_thr_wr;
  logic [31:0]   mask, ctrl, mode, div;
  logic [31:0]   rdata_nxt;

  function automatic logic at(input logic [AW-1:0] a, input logic [11:0] off);
    return a == AW'(off);
  endfunction

  assign wr_en       = bus_sel && bus_wr;
  assign rd_en       = bus_sel && !bus_wr;
  assign q_pop       = rd_en && at(bus_addr, OFF_RHR);
  assign evt_thr_wr  = wr_en && at(bus_addr, OFF_THR);
  assign evt_clr_all = rd_en && at(bus_addr, OFF_STAT) && (q_count == '0);

  dbgu_rxq #(.DEPTH(DEPTH), .W(8)) u_rxq (
    .clk(clk), .rst_n(rst_n),
    .push_req(rx_valid), .din(rx_byte), .pop_req(q_pop),
    .push_ok(q_push), .drop(q_drop), .count(q_count), .head(q_head)
  );

  dbgu_irq u_irq (
    .clk(clk), .rst_n(rst_n),
    .set_en(wr_en && at(bus_addr, OFF_IEN)),
    .clr_en(wr_en && at(bus_addr, OFF_IDIS)),
    .wdata(bus_wdata),
    .evt_rx(q_push), .evt_tx(evt_thr_wr), .clr_all(evt_clr_all),
    .mask(mask), .irq(irq)
  );

  dbgu_cfg u_cfg (
    .clk(clk), .rst_n(rst_n),
    .we_ctrl(wr_en && at(bus_addr, OFF_CTRL)),
    .we_mode(wr_en && at(bus_addr, OFF_MODE)),
    .we_div (wr_en && at(bus_addr, OFF_DIV)),
    .wdata(bus_wdata),
    .ctrl(ctrl), .mode(mode), .div(div)
  );

  always_comb begin
    rdata_nxt = '0;
    if (at(bus_addr, OFF_CTRL))      rdata_nxt = ctrl;
    else if (at(bus_addr, OFF_MODE)) rdata_nxt = mode;
    else if (at(bus_addr, OFF_MASK)) rdata_nxt = mask;
    else if (at(bus_addr, OFF_STAT)) rdata_nxt = status_word(q_count != '0, ovr_flag);
    else if (at(bus_addr, OFF_RHR))  rdata_nxt = (q_count != '0) ? {24'd0, q_head} : '0;
    else if (at(bus_addr, OFF_DIV))  rdata_nxt = div;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata <= '0;
      tx_valid  <= 1'b0;
      tx_byte   <= '0;
      ovr_flag  <= 1'b0;
    end else begin
      if (rd_en)      bus_rdata <= rdata_nxt;
      tx_valid <= evt_thr_wr;
      if (evt_thr_wr) tx_byte <= bus_wdata[7:0];
      if (q_drop)     ovr_flag <= 1'b1;
    end
  end
endmodule

// File: rtl/dbgu_chk.sv
module dbgu_chk #(
  parameter int DEPTH = 16,
  parameter int AW    = 9,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_sel,
  input logic          bus_wr,
  input logic [AW-1:0] bus_addr,
  input logic [31:0]   bus_wdata,
  input logic [31:0]   bus_rdata,
  input logic          tx_valid,
  input logic [7:0]    tx_byte,
  input logic          irq,
  input logic [CW-1:0] q_count,
  input logic          q_push,
  input logic          q_drop,
  input logic          ovr_flag,
  input logic [31:0]   mask,
  input logic          evt_clr_all
);
  import dbgu_pkg::*;
  logic wr_thr, wr_ien, wr_idis, rd_rhr, rd_stat;
  assign wr_thr  = bus_sel && bus_wr && bus_addr == AW'(OFF_THR);
  assign wr_ien  = bus_sel && bus_wr && bus_addr == AW'(OFF_IEN);
  assign wr_idis = bus_sel && bus_wr && bus_addr == AW'(OFF_IDIS);
  assign rd_rhr  = bus_sel && !bus_wr && bus_addr == AW'(OFF_RHR);
  assign rd_stat = bus_sel && !bus_wr && bus_addr == AW'(OFF_STAT);

  p_count_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    q_count <= CW'(DEPTH));
  p_empty_pop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rhr && q_count == '0) |=> bus_rdata == 32'd0);
  p_drop_sets_ovr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    q_drop |=> ovr_flag);
  p_ovr_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_flag |=> ovr_flag);
  p_status_fixed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stat |=> (bus_rdata[ST_TXRDY] && bus_rdata[ST_TXEMP] && bus_rdata[ST_TXBUF]));
  p_mask_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ien |=> (mask & $past(bus_wdata)) == $past(bus_wdata));
  p_mask_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_idis |=> (mask & $past(bus_wdata)) == 32'd0);
  p_rx_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (q_push && mask[MB_RX]) |=> irq);
  p_tx_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_thr |=> (tx_valid && tx_byte == $past(bus_wdata[7:0])));
  p_tx_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_thr |=> !tx_valid);
  p_clear_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_clr_all && !q_push) |=> !irq);
endmodule

bind dbg_uart_regs dbgu_chk #(.DEPTH(DEPTH), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .tx_valid(tx_valid), .tx_byte(tx_byte), .irq(irq),
  .q_count(q_count), .q_push(q_push), .q_drop(q_drop),
  .ovr_flag(ovr_flag), .mask(mask), .evt_clr_all(evt_clr_all)
);

// File: tb/sim_dbg_uart_regs.sv
module sim_dbg_uart_regs;
  localparam int DEPTH = 16;
  localparam int AW    = 9;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_sel = 1'b0, bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          rx_valid = 1'b0;
  logic [7:0]    rx_byte = '0;
  logic          tx_valid;
  logic [7:0]    tx_byte;
  logic          irq;

  int n_cmp = 0, n_bad = 0;
  string tag = "R1";
  bit done = 0;

  always #10 clk = ~clk;

  dbg_uart_regs #(.DEPTH(DEPTH), .AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .tx_valid(tx_valid),
    .tx_byte(tx_byte), .irq(irq)
  );

  // behavioural model
  byte unsigned mq[$];
  int unsigned  m_mask, m_ctrl, m_mode, m_div, m_rdata;
  bit           m_ovr, m_prx, m_ptx, m_txv;
  byte unsigned m_txb;

  always @(posedge clk) begin
    if (!rst_n) begin
      mq.delete();
      m_mask = 0; m_ctrl = 0; m_mode = 0; m_div = 0; m_rdata = 0;
      m_ovr = 0; m_prx = 0; m_ptx = 0; m_txv = 0; m_txb = 0;
    end else begin
      int unsigned mold;
      bit was_full, was_empty;
      mold = m_mask;
      was_full  = (mq.size() == DEPTH);
      was_empty = (mq.size() == 0);
      m_txv = 0;
      if (bus_sel && bus_wr) begin
        case (int'(bus_addr))
          'h000: m_ctrl = bus_wdata & 32'hFC;
          'h004: m_mode = bus_wdata & 32'hFFF;
          'h008: m_mask = m_mask | bus_wdata;
          'h00C: m_mask = m_mask & ~bus_wdata;
          'h01C: begin
            m_txv = 1; m_txb = bus_wdata[7:0];
            if (mold[4]) m_ptx = 1;
          end
          'h020: m_div = bus_wdata & 32'hFFFF;
          default: ;
        endcase
      end else if (bus_sel) begin
        case (int'(bus_addr))
          'h000: m_rdata = m_ctrl;
          'h004: m_rdata = m_mode;
          'h010: m_rdata = m_mask;
          'h014: begin
            m_rdata = 32'hA02 | (was_empty ? 0 : 1) | (m_ovr ? 32'h20 : 0);
            if (was_empty) begin m_prx = 0; m_ptx = 0; end
          end
          'h018: m_rdata = was_empty ? 0 : mq.pop_front();
          'h020: m_rdata = m_div;
          default: m_rdata = 0;
        endcase
      end
      if (rx_valid) begin
        if (was_full) m_ovr = 1;
        else begin
          mq.push_back(rx_byte);
          if (mold[0]) m_prx = 1;
        end
      end
    end
  end

  task automatic chk(input string t, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %08h expected %08h", t, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk({tag, " irq"}, {31'd0, irq}, {31'd0, m_prx | m_ptx});
      chk({tag, " rdata"}, bus_rdata, m_rdata);
      chk({tag, " tx_valid"}, {31'd0, tx_valid}, {31'd0, m_txv});
      if (m_txv) chk({tag, " tx_byte"}, {24'd0, tx_byte}, {24'd0, m_txb});
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = AW'(a); bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input int a, input logic [31:0] exp, input string t);
    bus_sel = 1; bus_wr = 0; bus_addr = AW'(a);
    @(negedge clk);
    bus_sel = 0;
    chk(t, bus_rdata, exp);
  endtask

  task automatic push(input logic [7:0] b);
    rx_valid = 1; rx_byte = b;
    @(negedge clk);
    rx_valid = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    tag = "R1";
    chk("R1 irq after reset", {31'd0, irq}, 32'd0);
    rd('h014, 32'h0000_0A02, "R1 status after reset");
    rd('h010, 32'd0, "R1 mask after reset");
    rd('h000, 32'd0, "R1 control after reset");
    rd('h020, 32'd0, "R1 divisor after reset");
    rd('h018, 32'd0, "R6 empty pop after reset");
    // R3 field trimming
    tag = "R3";
    wr('h000, 32'hFFFF_FFFF); rd('h000, 32'hFC, "R3 control trim");
    wr('h004, 32'hFFFF_FFFF); rd('h004, 32'hFFF, "R3 mode trim");
    wr('h020, 32'hFFFF_FFFF); rd('h020, 32'hFFFF, "R3 divisor trim");
    wr('h000, 32'h0000_0157); rd('h000, 32'h54, "R3 control pattern");
    // R2 decode
    tag = "R2";
    wr('h010, 32'hFFFF_FFFF); rd('h010, 32'd0, "R2 mask write ignored");
    wr('h014, 32'hFFFF_FFFF); wr('h124, 32'hFFFF_FFFF); wr('h040, 32'hFFFF_FFFF);
    wr('h002, 32'hFFFF_FFFF);
    rd('h000, 32'h54, "R2 control untouched");
    rd('h004, 32'hFFF, "R2 mode untouched");
    rd('h124, 32'd0, "R2 transfer-status reads 0");
    rd('h008, 32'd0, "R2 enable port reads 0");
    rd('h00C, 32'd0, "R2 disable port reads 0");
    rd('h01C, 32'd0, "R2 transmit port reads 0");
    rd('h044, 32'd0, "R2 unmapped reads 0");
    rd('h001, 32'd0, "R2 unaligned reads 0");
    chk("R2 irq untouched", {31'd0, irq}, 32'd0);
    // R4 mask
    tag = "R4";
    wr('h008, 32'h11);  rd('h010, 32'h11, "R4 enable sets");
    wr('h008, 32'h100); rd('h010, 32'h111, "R4 enable ORs");
    wr('h00C, 32'h101); rd('h010, 32'h10, "R4 disable clears");
    // R9 transmit
    tag = "R9";
    wr('h01C, 32'h0000_01A5);
    chk("R9 tx_valid pulse", {31'd0, tx_valid}, 32'd1);
    chk("R9 tx_byte", {24'd0, tx_byte}, 32'hA5);
    chk("R9 tx irq", {31'd0, irq}, 32'd1);
    @(negedge clk);
    chk("R9 tx pulse ends", {31'd0, tx_valid}, 32'd0);
    // R10 clear on empty status read
    tag = "R10";
    rd('h014, 32'hA02, "R10 status empty");
    chk("R10 irq cleared", {31'd0, irq}, 32'd0);
    // R8 receive interrupt
    tag = "R8";
    wr('h008, 32'h1);
    push(8'h3C);
    chk("R8 rx irq", {31'd0, irq}, 32'd1);
    rd('h014, 32'hA03, "R5 status nonempty");
    chk("R10 irq kept when nonempty", {31'd0, irq}, 32'd1);
    rd('h018, 32'h3C, "R6 pop byte");
    rd('h014, 32'hA02, "R10 status after drain");
    chk("R10 irq cleared after drain", {31'd0, irq}, 32'd0);
    // R6/R7 fill past depth
    tag = "R7";
    for (int i = 0; i < DEPTH + 4; i++) push(8'(i * 7 + 1));
    rd('h014, 32'hA23, "R7 overrun and ready");
    tag = "R6";
    for (int i = 0; i < DEPTH; i++) rd('h018, 32'(8'(i * 7 + 1)), "R6 FIFO order");
    rd('h018, 32'd0, "R6 pop when empty");
    rd('h014, 32'hA22, "R7 overrun sticky");
    // R7 full with pop in the same cycle: the byte is dropped
    for (int i = 0; i < DEPTH; i++) push(8'(i));
    rx_valid = 1; rx_byte = 8'hEE;
    rd('h018, 32'h00, "R7 pop while full");
    rx_valid = 0;
    for (int i = 1; i < DEPTH; i++) rd('h018, 32'(i), "R7 drained in order");
    rd('h018, 32'd0, "R7 offered byte dropped");
    // R10 arrival in the clearing cycle wins
    tag = "R10";
    rd('h014, 32'hA22, "R10 clear");
    rx_valid = 1; rx_byte = 8'h5A;
    rd('h014, 32'hA22, "R10 status same cycle");
    rx_valid = 0;
    chk("R10 arrival wins", {31'd0, irq}, 32'd1);
    rd('h018, 32'h5A, "R10 byte kept");
    // R11 read data held
    tag = "R11";
    repeat (3) @(negedge clk);
    chk("R11 rdata held", bus_rdata, 32'h5A);
    // R8 masked arrival does not raise irq
    tag = "R8";
    rd('h014, 32'hA22, "R8 clear");
    wr('h00C, 32'h1);
    push(8'h77);
    chk("R8 masked arrival", {31'd0, irq}, 32'd0);
    rd('h018, 32'h77, "R8 masked byte stored");
    repeat (2) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule